// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block conditions four asynchronous external interrupt pins and presents each one as a pending request to a downstream interrupt aggregator. Pin 0 is reported on a dedicated critical-group output. Pins 1 to 3 are reported on the main-group outputs at indices 1 to 3. Each pin passes through a synchroniser and is then evaluated in one of four sense modes: active-high level, rising edge, falling edge or active-low level. In the edge modes, a detected edge is held in a sticky flag until software acknowledges it.

All configuration sits in one packed 32-bit control word, which is reached through a single-register write strobe and a combinational read port. The word holds, for each pin, an enable bit, a write-one-to-clear acknowledge bit and a two-bit sense code. It also holds a master enable for all external pins and a routing bit for critical requests, which is brought out as a pin. Arbitration between groups is left to the aggregator.

Top module: `ext_irq_sense`

## Requirements
- R1: Control bit (11 − n) enables pin n when it is 1. A disabled pin never shows pending, and edges on it are not latched.
- R2: Writing 1 to control bit (27 − n) clears the latched edge of pin n. Writing 0 there has no effect, and bits 27:24 always read as 0.
- R3: The sense code of pin n sits at bits (23 − 2n):(22 − 2n). Code 0 is level high, 1 is rising edge, 2 is falling edge and 3 is level low. The code reads back as it was written.
- R4: Bit 12 is a master enable. While it is 0, no pin shows pending and no edge is latched.
- R5: Bit 0 is stored, reads back, and drives output `critRouteNormal`.
- R6: Pin 0 drives `critPend`. Pin n (1 to 3) drives `mainPend[n]`. A pin never affects another pin's output.
- R7: A pin change reaches the detector through two synchroniser flops. A level-mode result appears two clock edges after the input changes, and an edge-mode result appears three clock edges after it.
- R8: In an edge mode, a matching edge sets a pending flag that holds until it is acknowledged. In a level mode, pending follows the synchronised pin directly, with the polarity the code selects.
- R9: After reset, the control word is 0 and every output is 0. Bits outside the fields above are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Write strobe for the control word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Current control word, with the acknowledge bits reading 0 |
| extPin | input | 4 | Asynchronous external interrupt pins |
| critPend | output | 1 | Pending request from pin 0 to the critical group |
| mainPend | output | 3 | Pending requests from pins 1 to 3 (indices 3:1) to the main group |
| critRouteNormal | output | 1 | Routing select for critical requests (bit 0) |

## Verification
A register write takes effect on the next clock edge. A pin change shows up on a level-mode output after two edges and on an edge-mode output after three. The bench drives stimulus on falling edges and counts rising edges before it samples. At the second edge it checks that level modes have already moved and edge modes have not. At the third edge it checks the latched edge. Every case sweeps all pins, sense codes, enable values and master enable values, and it compares the whole four-bit pending vector, so crosstalk between pins would be caught.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int NUM_PINS  = 4;
  localparam int WORD_W    = 32;
  localparam int EN_TOP    = 11;
  localparam int ACK_TOP   = 27;
  localparam int SENSE_TOP = 23;
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;

  typedef enum logic [1:0] {
    SENSE_LVL_HIGH = 2'd0,
    SENSE_RISE     = 2'd1,
    SENSE_FALL     = 2'd2,
    SENSE_LVL_LOW  = 2'd3
  } sense_e;

  typedef struct packed {
    logic [NUM_PINS-1:0]      pinEn;
    logic [NUM_PINS-1:0]      ackPulse;
    logic [NUM_PINS-1:0][1:0] sense;
    logic                     masterEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/eirq_ctrl.sv
module eirq_ctrl
  import eirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output ctrlStrobes_t      strobes,
  output logic              critRouteNormal
);
  localparam logic [WORD_W-1:0] USED_MASK = 32'h0FFF_1F01;

  logic [NUM_PINS-1:0]      enReg;
  logic [NUM_PINS-1:0][1:0] senseReg;
  logic                     masterReg;
  logic                     routeReg;
  logic                     unusedWdata;

  assign unusedWdata = ^(regWdata & ~USED_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg     <= '0;
      senseReg  <= '0;
      masterReg <= 1'b0;
      routeReg  <= 1'b0;
    end else if (regWe) begin
      for (int n = 0; n < NUM_PINS; n++) begin
        enReg[n]    <= regWdata[EN_TOP-n];
        senseReg[n] <= regWdata[SENSE_TOP-2*n -: 2];
      end
      masterReg <= regWdata[MASTER_BIT];
      routeReg  <= regWdata[ROUTE_BIT];
    end
  end

  always_comb begin
    regRdata = '0;
    for (int n = 0; n < NUM_PINS; n++) begin
      regRdata[EN_TOP-n]              = enReg[n];
      regRdata[SENSE_TOP-2*n -: 2]    = senseReg[n];
      strobes.ackPulse[n]             = regWe & regWdata[ACK_TOP-n];
    end
    regRdata[MASTER_BIT] = masterReg;
    regRdata[ROUTE_BIT]  = routeReg;
    strobes.pinEn        = enReg;
    strobes.sense        = senseReg;
    strobes.masterEn     = masterReg;
  end

  assign critRouteNormal = routeReg;
endmodule

// File: rtl/eirq_datapath.sv
module eirq_datapath
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] extPin,
  input  ctrlStrobes_t        strobes,
  output logic [NUM_PINS-1:0] pendOut
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic [SYNC_STAGES:0] pipe;
    logic   cur, prev, live, rise, fall, edgeHit, sticky, selVal;
    sense_e mode;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '0;
      else       pipe <= {pipe[SYNC_STAGES-1:0], extPin[g]};
    end

    assign cur  = pipe[SYNC_STAGES-1];
    assign prev = pipe[SYNC_STAGES];
    assign mode = sense_e'(strobes.sense[g]);
    assign live = strobes.pinEn[g] & strobes.masterEn;
    assign rise = cur & ~prev;
    assign fall = ~cur & prev;
    assign edgeHit = live & (((mode == SENSE_RISE) & rise) |
                             ((mode == SENSE_FALL) & fall));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    sticky <= 1'b0;
      else if (edgeHit)             sticky <= 1'b1;
      else if (strobes.ackPulse[g]) sticky <= 1'b0;
    end

    always_comb begin
      case (mode)
        SENSE_LVL_HIGH: selVal = cur;
        SENSE_LVL_LOW:  selVal = ~cur;
        default:        selVal = sticky;
      endcase
    end

    assign pendOut[g] = live & selVal;
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic [3:0]  extPin,
  output logic        critPend,
  output logic [3:1]  mainPend,
  output logic        critRouteNormal
);
  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] pendVec;

  eirq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .strobes(strobes), .critRouteNormal(critRouteNormal)
  );

  eirq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .strobes(strobes), .pendOut(pendVec)
  );

  assign critPend = pendVec[0];
  assign mainPend = pendVec[3:1];
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker (
  input logic        clk,
  input logic        rstN,
  input logic        regWe,
  input logic [31:0] regWdata,
  input logic [31:0] regRdata,
  input logic        critPend,
  input logic [3:1]  mainPend
);
  logic [3:0] allPend;
  assign allPend = {mainPend, critPend};

  p_master_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    !regRdata[12] |-> allPend == 4'b0);

  p_enable_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (allPend & ~{regRdata[8], regRdata[9], regRdata[10], regRdata[11]}) == 4'b0);

  p_ack_reads_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[27:24] == 4'b0);

  p_sense_store_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> regRdata[23:16] == $past(regWdata[23:16]));

  p_edge_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata[23:22] == 2'd1 && critPend && !regWe) |=> critPend);
endmodule

bind ext_irq_sense eirq_checker u_chk (.*);

// File: tb/tb_ext_irq_sense.sv
module tb_ext_irq_sense;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [3:0]  extPin = '0;
  logic        critPend;
  logic [3:1]  mainPend;
  logic        critRouteNormal;
  int          nRun = 0;
  int          nFail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [31:0] w);
    @(negedge clk); regWe = 1'b1; regWdata = w;
    @(negedge clk); regWe = 1'b0; regWdata = '0;
  endtask

  task automatic waitEdges(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [31:0] ctrlWord(input int n, input int mode, input bit en,
                                           input bit mst, input bit ack);
    logic [31:0] w = '0;
    w[11-n] = en;
    w[23-2*n -: 2] = 2'(mode);
    w[12] = mst;
    w[0] = 1'b1;
    if (ack) w[27:24] = 4'hF;
    return w;
  endfunction

  function automatic bit lvl(input int mode, input bit pin);
    return (mode == 0) ? pin : (mode == 3) ? ~pin : 1'b0;
  endfunction

  function automatic logic [31:0] pv();
    return {28'b0, mainPend, critPend};
  endfunction

  task automatic runCase(input int n, input int mode, input bit en, input bit mst);
    bit live = en & mst;
    bit isEdge = (mode == 1) || (mode == 2);
    logic [31:0] w = ctrlWord(n, mode, en, mst, 1'b1);
    extPin = '0;
    waitEdges(4);
    wrCtrl(w);
    check("R1/R3/R4/R6 idle", pv(), 32'(live & lvl(mode, 0)) << n);
    check("R2/R3 readback", regRdata, w & ~32'h0F00_0000);
    extPin[n] = 1'b1;
    waitEdges(2);
    check("R7 two-edge sync", pv(), isEdge ? 32'd0 : 32'(live & lvl(mode, 1)) << n);
    waitEdges(1);
    check("R8 rise latch", pv(),
          (isEdge ? 32'(live && mode == 1) : 32'(live & lvl(mode, 1))) << n);
    extPin[n] = 1'b0;
    waitEdges(3);
    check("R8 fall/sticky", pv(), (isEdge ? 32'(live) : 32'(live & lvl(mode, 0))) << n);
    wrCtrl(ctrlWord(n, mode, en, mst, 1'b0));
    check("R2 zero ack no effect", pv(), (isEdge ? 32'(live) : 32'(live & lvl(mode, 0))) << n);
    wrCtrl(w);
    check("R2 ack clears", pv(), 32'(live & lvl(mode, 0)) << n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset word", regRdata, 32'd0);
    check("R9 reset pend", pv(), 32'd0);
    check("R9 reset route", 32'(critRouteNormal), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    wrCtrl(32'hFFFF_FFFF);
    check("R9 unused bits", regRdata, 32'h00FF_1F01);
    check("R5 route set", 32'(critRouteNormal), 32'd1);
    wrCtrl(32'h0000_0000);
    check("R5 route clear", 32'(critRouteNormal), 32'd0);
    check("R5 readback", regRdata, 32'd0);
    for (int n = 0; n < 4; n++)
      for (int mode = 0; mode < 4; mode++)
        for (int e = 0; e < 2; e++)
          for (int m = 0; m < 2; m++)
            runCase(n, mode, 1'(e), 1'(m));
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule